// File: doc/BRIEF.md
# Colour Palette Lookup Table with Register Write Port

This block holds a 256-entry colour table, each entry carrying an 8-bit red, green and blue component. Software fills it through a 16-byte window of 32-bit registers. One register picks the entry to be written. A second register takes three writes in a row, which fill red, then green, then blue. After the blue write the entry pointer moves on by one, so a whole run of entries can be loaded by streaming component bytes.

A separate lookup port serves a display pipeline. It takes an 8-bit pixel code and returns the stored triple one clock later. Each time a colour component is written, the block raises a one-cycle notice that names the entry that changed, so caches further down the pipeline can refresh that entry.

Bus writes use a plain valid/write/address/data handshake with no wait states. Bus reads always return zero.

Top module: `palDac`

## Requirements
- R1: After reset, entries 0 to 254 hold (0,0,0) and entry 255 holds (255,255,255). The entry pointer is 0, the next component is red, and `updValid` is low.
- R2: A write to byte offset 0 sets the entry pointer to data bits 31:24 and makes red the next component to be written.
- R3: Each write to byte offset 4 stores data bits 31:24 into the pointed entry, filling red, green and blue in that order. Data bits 23:0 have no effect.
- R4: The blue write advances the entry pointer by one, wrapping from 255 to 0, and makes red the next component.
- R5: `busRdata` is always zero. An access with `busWrite` low changes no entry, no pointer and no phase.
- R6: A write to offset 8 or 12, or to an address whose bits 1:0 are not zero, changes no entry, no pointer and no phase.
- R7: `pixRgb` presents the entry chosen by `pixIndex` on the previous clock edge as {red[23:16], green[15:8], blue[7:0]}. A lookup of an entry written at the same edge returns the entry's previous contents.
- R8: One cycle after each accepted component write, `updValid` is high for exactly one cycle and `updIndex` names the entry that was written. At all other times `updValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Byte offset within the register window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, always zero |
| pixIndex | input | 8 | Pixel code to look up |
| pixRgb | output | 24 | Colour triple for the previous cycle's pixel code |
| updValid | output | 1 | One-cycle notice that an entry changed |
| updIndex | output | 8 | Entry named by the notice |

## Verification
The bench streams long runs of component writes across the 255-to-0 pointer wrap. A design that fails to wrap, or that skips an entry, puts later colours in the wrong place. It reloads the pointer in the middle of a triple to confirm the phase goes back to red; a design that kept the old phase would write green or blue where red belongs. Writes to unused and misaligned offsets, and read accesses, are mixed in among real writes; a loose address decode would corrupt entries or shift the phase. The bench also looks up an entry at the same edge that entry is written, to catch a lookup that passes new data through, and after reset it checks that white sits at entry 255 and not at entry 0.

// File: rtl/palDacPkg.sv
package palDacPkg;
  parameter int IDX_W   = 8;
  parameter int CH_W    = 8;
  parameter int BUS_W   = 32;
  parameter int ADDR_W  = 4;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NCH     = 3;
  localparam int RGB_W   = NCH * CH_W;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef struct packed {
    logic             we;
    phase_e           chan;
    logic [IDX_W-1:0] idx;
    logic [CH_W-1:0]  val;
  } palStrobe_t;
endpackage

// File: rtl/palDacCtrl.sv
module palDacCtrl
  import palDacPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output palStrobe_t        strobe
);
  localparam int SEL_W = ADDR_W - 2;

  logic [IDX_W-1:0] curIdx;
  phase_e           curPhase;
  logic             aligned;
  logic [SEL_W-1:0] wordSel;
  logic             wrIdx;
  logic             wrData;
  logic [CH_W-1:0]  colourByte;
  logic             unusedLow;

  assign aligned    = (busAddr[1:0] == 2'b00);
  assign wordSel    = busAddr[ADDR_W-1:2];
  assign wrIdx      = busValid && busWrite && aligned && (wordSel == SEL_W'(0));
  assign wrData     = busValid && busWrite && aligned && (wordSel == SEL_W'(1));
  assign colourByte = busWdata[BUS_W-1 -: CH_W];
  assign unusedLow  = ^busWdata[BUS_W-CH_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= '0;
      curPhase <= PH_RED;
    end else if (wrIdx) begin
      curIdx   <= colourByte;
      curPhase <= PH_RED;
    end else if (wrData) begin
      unique case (curPhase)
        PH_RED:   curPhase <= PH_GREEN;
        PH_GREEN: curPhase <= PH_BLUE;
        default: begin
          curPhase <= PH_RED;
          curIdx   <= curIdx + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.we   = wrData;
    strobe.chan = curPhase;
    strobe.idx  = curIdx;
    strobe.val  = colourByte;
  end

  // R4: phase never takes the unused code
  p_phase_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    curPhase != phase_e'(2'd3));

  // R2: pointer load resets phase and takes the top byte
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx |=> (curPhase == PH_RED) && (curIdx == $past(busWdata[BUS_W-1 -: CH_W])));

  // R4: blue write advances the pointer with wrap
  p_idx_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && curPhase == PH_BLUE) |=> (curPhase == PH_RED) && (curIdx == IDX_W'($past(curIdx) + 1)));

  // R6: no accepted write leaves pointer and phase untouched
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrIdx || wrData) |=> $stable(curIdx) && $stable(curPhase));
endmodule

// File: rtl/palDacStore.sv
module palDacStore
  import palDacPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  palStrobe_t       strobe,
  input  logic [IDX_W-1:0] pixIndex,
  output logic [RGB_W-1:0] pixRgb,
  output logic             updValid,
  output logic [IDX_W-1:0] updIndex
);
  logic [CH_W-1:0] tab [NCH][ENTRIES];
  logic [RGB_W-1:0] lookRgb;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < ENTRIES; i++)
          tab[c][i] <= (i == ENTRIES - 1) ? '1 : '0;
      end else if (strobe.we && (int'(strobe.chan) == c)) begin
        tab[c][strobe.idx] <= strobe.val;
      end
    end
    // red occupies the top byte of the triple
    assign lookRgb[(NCH-c)*CH_W-1 -: CH_W] = tab[c][pixIndex];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixRgb   <= '0;
      updValid <= 1'b0;
      updIndex <= '0;
    end else begin
      pixRgb   <= lookRgb;
      updValid <= strobe.we;
      if (strobe.we) updIndex <= strobe.idx;
    end
  end

  // R8: every component write gives a notice naming its entry
  p_upd_notice_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.we |=> updValid && (updIndex == $past(strobe.idx)));

  // R8: no notice without a write
  p_upd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.we |=> !updValid);
endmodule

// File: rtl/palDac.sv
module palDac
  import palDacPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [IDX_W-1:0]  pixIndex,
  output logic [RGB_W-1:0]  pixRgb,
  output logic              updValid,
  output logic [IDX_W-1:0]  updIndex
);
  palStrobe_t strobe;

  assign busRdata = '0;

  palDacCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe)
  );

  palDacStore u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixIndex(pixIndex),
    .pixRgb(pixRgb), .updValid(updValid), .updIndex(updIndex)
  );
endmodule

// File: tb/palDac_bench.sv
module palDac_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pixIndex = '0;
  logic [23:0] pixRgb;
  logic        updValid;
  logic [7:0]  updIndex;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] model [256];
  logic [7:0]  mIdx;
  int          mPhase;

  palDac u_palDac (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pixIndex(pixIndex), .pixRgb(pixRgb), .updValid(updValid), .updIndex(updIndex)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] setChan(logic [23:0] old, int ph, logic [7:0] v);
    logic [23:0] n = old;
    n[23 - 8*ph -: 8] = v;
    return n;
  endfunction

  function automatic bit acceptedIdx(logic w, logic [3:0] a);
    return w && (a == 4'd0);
  endfunction

  function automatic bit acceptedData(logic w, logic [3:0] a);
    return w && (a == 4'd4);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 256; i++) model[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    mIdx = 0;
    mPhase = 0;
  endtask

  // one bus access; checks the notice and read data afterwards
  task automatic busOp(logic w, logic [3:0] a, logic [31:0] d, string req);
    bit isData;
    logic [7:0] tgt;
    @(negedge clk);
    busValid = 1'b1; busWrite = w; busAddr = a; busWdata = d;
    check(busRdata == 32'h0, "R5", busRdata, 32'h0);
    isData = acceptedData(w, a);
    tgt = mIdx;
    if (acceptedIdx(w, a)) begin
      mIdx = d[31:24]; mPhase = 0;
    end else if (isData) begin
      model[mIdx] = setChan(model[mIdx], mPhase, d[31:24]);
      if (mPhase == 2) begin mPhase = 0; mIdx = mIdx + 8'd1; end
      else mPhase++;
    end
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    check(updValid == isData, isData ? "R8" : req, 32'(updValid), 32'(isData));
    if (isData) check(updIndex == tgt, "R8", 32'(updIndex), 32'(tgt));
  endtask

  task automatic lookup(logic [7:0] idx, string req);
    @(negedge clk);
    pixIndex = idx;
    @(negedge clk);
    check(pixRgb == model[idx], req, 32'(pixRgb), 32'(model[idx]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(updValid == 1'b0, "R1", 32'(updValid), 0);
    for (int i = 0; i < 256; i++) lookup(8'(i), "R1");

    // reset pointer/phase: first data write lands on entry 0 red
    busOp(1, 4'd4, 32'hA1000000, "R1");
    lookup(8'd0, "R1");

    // directed: load pointer, full triple, low bits ignored
    busOp(1, 4'd0, 32'h10FFFFFF, "R2");
    busOp(1, 4'd4, 32'h11ABCDEF, "R3");
    busOp(1, 4'd4, 32'h22ABCDEF, "R3");
    busOp(1, 4'd4, 32'h33ABCDEF, "R3");
    lookup(8'h10, "R3");
    // pointer advanced to 0x11
    busOp(1, 4'd4, 32'h44000000, "R4");
    lookup(8'h11, "R4");

    // mid-triple pointer reload returns to red
    busOp(1, 4'd4, 32'h55000000, "R2");
    busOp(1, 4'd0, 32'h20000000, "R2");
    busOp(1, 4'd4, 32'h66000000, "R2");
    lookup(8'h20, "R2");
    lookup(8'h11, "R2");

    // wrap 255 -> 0
    busOp(1, 4'd0, 32'hFF000000, "R4");
    for (int k = 0; k < 4; k++) busOp(1, 4'd4, {8'(8'h70 + k), 24'h0}, "R4");
    lookup(8'hFF, "R4");
    lookup(8'h00, "R4");

    // ignored offsets and reads, then a data write reveals pointer/phase
    busOp(1, 4'd8,  32'h99000000, "R6");
    busOp(1, 4'd12, 32'h99000000, "R6");
    busOp(1, 4'd1,  32'h99000000, "R6");
    busOp(1, 4'd5,  32'h99000000, "R6");
    busOp(0, 4'd0,  32'h99000000, "R5");
    busOp(0, 4'd4,  32'h99000000, "R5");
    busOp(1, 4'd4, 32'h12000000, "R6");
    lookup(8'h00, "R6");
    lookup(8'h01, "R6");

    // same-edge write and lookup returns old contents
    busOp(1, 4'd0, 32'h40000000, "R7");
    @(negedge clk);
    pixIndex = 8'h40;
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'd4; busWdata = 32'hEE000000;
    begin
      logic [23:0] oldVal = model[8'h40];
      model[8'h40] = setChan(model[8'h40], 0, 8'hEE);
      mPhase = 1;
      @(negedge clk);
      busValid = 1'b0; busWrite = 1'b0;
      check(pixRgb == oldVal, "R7", 32'(pixRgb), 32'(oldVal));
      check(updValid && updIndex == 8'h40, "R8", 32'(updIndex), 32'h40);
      @(negedge clk);
      check(pixRgb == model[8'h40], "R7", 32'(pixRgb), 32'(model[8'h40]));
      check(updValid == 1'b0, "R8", 32'(updValid), 0);
    end

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      logic [3:0] a;
      logic w = 1'b1;
      if (r < 70) a = 4'd4;
      else if (r < 80) a = 4'd0;
      else if (r < 90) begin a = 4'($urandom_range(0, 15)); end
      else begin a = 4'd4; w = 1'b0; end
      busOp(w, a, $urandom(), "R6");
      if (n % 8 == 0) lookup(8'($urandom_range(0, 255)), "R3");
    end
    for (int i = 0; i < 256; i++) lookup(8'(i), "R3");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule